// File: doc/BRIEF.md
# Tagged Memory Controller

This block owns a local memory of 64-bit words and keeps one validity bit, the tag, beside every word. A single request port accepts byte, half-word (16-bit), word (32-bit) and capability (64-bit plus tag) accesses, both loads and stores. The tag sits in a separate array with no address of its own. It can only be seen through a capability load and only be set through a capability store. Any ordinary data store that touches a word wipes that word's tag. A stale or forged pointer in memory therefore never reads back as valid.

Each accepted request is answered exactly one cycle later. Loads return data, and capability loads also return the tag. Stores return a plain acknowledgement. Requests that break the alignment rules return an error and leave both arrays untouched. Reset clears every tag. The data array is not reset.

Top module: `tagged_mem_ctrl`

## Requirements
- R1: After reset every tag reads as 0 on a capability load, and `rsp_valid` is low until a request is accepted.
- R2: `req_ready` equals `rst_n`. A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. Exactly one response (`rsp_valid` high for one cycle) follows each accepted request, in the next cycle. No response appears otherwise.
- R3: `req_kind` is encoded 0 = byte, 1 = half-word, 2 = word, 3 = capability. `req_addr` is a byte address whose bits [2:0] select the byte lane (little-endian) and whose upper bits select the 64-bit word. A data load (kind 0 to 2) returns the addressed bytes zero-extended in the low bits of `rsp_rdata`, returns `rsp_tag` = 0, and leaves the stored tag unchanged.
- R4: A data store writes only the addressed bytes, taking them from the low bits of `req_wdata`. All other bytes of the word keep their value.
- R5: A successful data store of any size clears the tag of the word it touches.
- R6: A capability store with bits [2:0] of the address at zero writes all 64 bits of `req_wdata` and sets the word's tag to `req_wtag` in the same operation.
- R7: An aligned capability load returns the full 64-bit word together with its tag.
- R8: A capability access whose address bits [2:0] are not zero gets `rsp_err` = 1, and neither the data nor the tag array changes.
- R9: A half-word access with address bit 0 set, or a word access with address bits [1:0] not zero, gets `rsp_err` = 1 and changes no state.
- R10: An error response carries `rsp_rdata` = 0 and `rsp_tag` = 0.
- R11: A successful store responds with `rsp_err` = 0, `rsp_rdata` = 0 and `rsp_tag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (high out of reset) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_kind | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 capability |
| req_addr | input | ADDR_W (9) | Byte address |
| req_wdata | input | 64 | Store data, right-aligned for data stores |
| req_wtag | input | 1 | Tag of a stored capability |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_err | output | 1 | Request rejected for misalignment |
| rsp_rdata | output | 64 | Load data |
| rsp_tag | output | 1 | Tag returned by a capability load |

## Verification
A tag bit left set after a data store, or dropped by a capability store, shows up at the next capability load of that word. The bench reads every word back with capability loads after each stimulus phase and after a long random mix, so a tag error reaches the ports within one sweep. A wrong byte-lane enable or shift corrupts neighbouring bytes, which the following full-word load exposes. A rejected access that leaks into either array shows up on the read-back that comes right after it. Handshake or response-timing faults show on the cycle after any request or idle slot, because `rsp_valid` is compared on every clock.

// File: rtl/tmc_pkg.sv
// Shared types and helpers for the tagged memory controller.
// Assumes 64-bit words split into eight byte lanes.
package tmc_pkg;
    localparam int unsigned LANES     = 8;
    localparam int unsigned WORD_BITS = 64;
    localparam int unsigned OFF_W     = $clog2(LANES);

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_CAP  = 2'd3
    } acc_kind_e;

    // Control state carried from the request cycle to the response cycle.
    typedef struct packed {
        logic            valid;
        logic            we;
        acc_kind_e       kind;
        logic [OFF_W-1:0] off;
        logic            err;
    } rsp_ctl_t;

    // Unshifted byte-lane mask covering the access size.
    function automatic logic [LANES-1:0] size_mask(acc_kind_e k);
        case (k)
            ACC_BYTE: return 8'h01;
            ACC_HALF: return 8'h03;
            ACC_WORD: return 8'h0F;
            default:  return 8'hFF;
        endcase
    endfunction

    // Right-aligned data mask covering the access size.
    function automatic logic [WORD_BITS-1:0] data_mask(acc_kind_e k);
        case (k)
            ACC_BYTE: return 64'h0000_0000_0000_00FF;
            ACC_HALF: return 64'h0000_0000_0000_FFFF;
            ACC_WORD: return 64'h0000_0000_FFFF_FFFF;
            default:  return '1;
        endcase
    endfunction

    // Natural alignment of the lane offset for the access size.
    function automatic logic is_aligned(acc_kind_e k, logic [OFF_W-1:0] off);
        case (k)
            ACC_BYTE: return 1'b1;
            ACC_HALF: return off[0] == 1'b0;
            ACC_WORD: return off[1:0] == 2'b00;
            default:  return off == '0;
        endcase
    endfunction
endpackage

// File: rtl/tmc_req_decode.sv
// Request decoder: checks alignment and produces byte enables, lane-shifted
// store data and tag-update controls for one accepted request.
// Assumes the caller qualifies `acc` with the handshake.
module tmc_req_decode
    import tmc_pkg::*;
#(
    parameter int unsigned IDX_W = 6,
    localparam int unsigned ADDR_W = IDX_W + OFF_W
) (
    input  logic                 acc,
    input  logic                 we,
    input  acc_kind_e            kind,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic                 wtag,
    output logic [IDX_W-1:0]     idx,
    output logic [OFF_W-1:0]     off,
    output logic                 err,
    output logic                 ram_we,
    output logic                 ram_re,
    output logic [LANES-1:0]     ram_be,
    output logic [WORD_BITS-1:0] ram_wdata,
    output logic                 tag_we,
    output logic                 tag_wval
);
    assign idx = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    // Decode one request into array controls.
    always_comb begin
        err       = acc && !is_aligned(kind, off);
        ram_we    = acc && !err && we;
        ram_re    = acc && !err && !we;
        ram_be    = size_mask(kind) << off;
        ram_wdata = wdata << {off, 3'b000};
        tag_we    = ram_we;
        tag_wval  = (kind == ACC_CAP) ? wtag : 1'b0;
    end
endmodule

// File: rtl/tmc_data_ram.sv
// Data array: DEPTH words of eight independent byte lanes with a registered
// read port. Not reset; contents are undefined until written.
module tmc_data_ram
    import tmc_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 we,
    input  logic                 re,
    input  logic [LANES-1:0]     be,
    input  logic [WORD_BITS-1:0] wdata,
    output logic [WORD_BITS-1:0] q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] q_lane;

        // Write the lane when enabled, register the lane on a read.
        always_ff @(posedge clk) begin
            if (we && be[l]) mem[idx] <= wdata[l*8 +: 8];
            if (re)          q_lane   <= mem[idx];
        end

        assign q[l*8 +: 8] = q_lane;
    end
endmodule

// File: rtl/tmc_tag_array.sv
// Tag array: one bit per data word, held in flops so that reset clears every
// tag in a single cycle. Registered read port aligned with the data array.
module tmc_tag_array #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic             wval,
    input  logic             re,
    output logic             q
);
    logic [DEPTH-1:0] tags;

    // Clear all tags on reset, otherwise update the addressed tag.
    always_ff @(posedge clk) begin
        if (!rst_n)  tags      <= '0;
        else if (we) tags[idx] <= wval;
    end

    // Register the addressed tag on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (re) q <= tags[idx];
    end
endmodule

// File: rtl/tmc_rsp_format.sv
// Response stage: remembers what the accepted request was and shapes the
// registered array outputs into the response one cycle later.
module tmc_rsp_format
    import tmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  rsp_ctl_t             ctl_in,
    input  logic [WORD_BITS-1:0] ram_q,
    input  logic                 tag_q,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [WORD_BITS-1:0] rsp_rdata,
    output logic                 rsp_tag
);
    rsp_ctl_t ctl;

    // Capture the request controls for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= '0;
        else        ctl <= ctl_in;
    end

    // Select lanes and gate data and tag by access kind and outcome.
    always_comb begin
        logic load_ok;
        load_ok   = ctl.valid && !ctl.err && !ctl.we;
        rsp_valid = ctl.valid;
        rsp_err   = ctl.valid && ctl.err;
        rsp_rdata = load_ok ? ((ram_q >> {ctl.off, 3'b000}) & data_mask(ctl.kind)) : '0;
        rsp_tag   = load_ok && (ctl.kind == ACC_CAP) && tag_q;
    end
endmodule

// File: rtl/tagged_mem_ctrl.sv
// Tagged memory controller top: one request port in front of a data array
// of 64-bit words and a one-bit-per-word tag array. Data stores clear the
// tag, capability stores write data and tag together, misaligned requests
// are rejected. Responses come one cycle after acceptance.
module tagged_mem_ctrl
    import tmc_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = IDX_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_BITS-1:0] req_wdata,
    input  logic                 req_wtag,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [WORD_BITS-1:0] rsp_rdata,
    output logic                 rsp_tag
);
    logic                 acc;
    acc_kind_e            kind;
    logic [IDX_W-1:0]     idx;
    logic [OFF_W-1:0]     off;
    logic                 err;
    logic                 ram_we, ram_re, tag_we, tag_wval;
    logic [LANES-1:0]     ram_be;
    logic [WORD_BITS-1:0] ram_wdata, ram_q;
    logic                 tag_q;
    rsp_ctl_t             ctl_next;

    assign req_ready = rst_n;
    assign acc       = req_valid && req_ready;
    assign kind      = acc_kind_e'(req_kind);

    tmc_req_decode #(.IDX_W(IDX_W)) u_dec (
        .acc(acc), .we(req_we), .kind(kind), .addr(req_addr),
        .wdata(req_wdata), .wtag(req_wtag),
        .idx(idx), .off(off), .err(err),
        .ram_we(ram_we), .ram_re(ram_re), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .tag_we(tag_we), .tag_wval(tag_wval)
    );

    tmc_data_ram #(.DEPTH(DEPTH)) u_data (
        .clk(clk), .idx(idx), .we(ram_we), .re(ram_re),
        .be(ram_be), .wdata(ram_wdata), .q(ram_q)
    );

    tmc_tag_array #(.DEPTH(DEPTH)) u_tag (
        .clk(clk), .rst_n(rst_n), .idx(idx), .we(tag_we),
        .wval(tag_wval), .re(ram_re), .q(tag_q)
    );

    // Bundle the request controls for the response stage.
    always_comb begin
        ctl_next.valid = acc;
        ctl_next.we    = req_we;
        ctl_next.kind  = kind;
        ctl_next.off   = off;
        ctl_next.err   = err;
    end

    tmc_rsp_format u_rsp (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_next),
        .ram_q(ram_q), .tag_q(tag_q),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag)
    );
endmodule

// File: rtl/tagged_mem_ctrl_chk.sv
// Port-level protocol checker for tagged_mem_ctrl, attached by bind.
module tagged_mem_ctrl_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              rsp_tag
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    // R2
    rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    // R8
    cap_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 2'd3 && req_addr[2:0] != 3'd0) |=> rsp_err);
    // R9
    word_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 2'd2 && req_addr[1:0] != 2'd0) |=> rsp_err);
    // R3
    data_load_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_we && req_kind != 2'd3) |=> !rsp_tag);
    // R10
    err_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 64'd0 && !rsp_tag));
    // R11
    cap_store_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_we && req_kind == 2'd3 && req_addr[2:0] == 3'd0)
        |=> (!rsp_err && rsp_rdata == 64'd0 && !rsp_tag));
endmodule

bind tagged_mem_ctrl tagged_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_kind(req_kind), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .rsp_tag(rsp_tag)
);

// File: tb/tb_tagged_mem_ctrl.sv
// Bench: behavioural byte/tag memory model compared with the DUT every cycle.
module tb_tagged_mem_ctrl;
    localparam int unsigned DEPTH  = 64;
    localparam int unsigned ADDR_W = $clog2(DEPTH) + 3;
    localparam int unsigned NBYTES = DEPTH * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic              req_wtag = 1'b0;
    logic              rsp_valid, rsp_err, rsp_tag;
    logic [63:0]       rsp_rdata;

    int compared = 0;
    int mismatched = 0;

    logic [7:0] bm [NBYTES];
    bit         kn [NBYTES];
    bit         tg [DEPTH];

    always #10 clk = ~clk;

    tagged_mem_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_wtag(req_wtag),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One request; checks the response on the following cycle.
    task automatic op(input bit we, input logic [1:0] k, input int unsigned a,
                      input logic [63:0] wd, input bit wt, input string rq);
        logic [63:0] er;
        bit et, ee, ekn;
        int unsigned n, w;
        n = (k == 2'd0) ? 1 : (k == 2'd1) ? 2 : (k == 2'd2) ? 4 : 8;
        w = a / 8;
        ee = (a % n) != 0;
        er = '0; et = 1'b0; ekn = 1'b1;
        if (!ee) begin
            if (we) begin
                for (int i = 0; i < int'(n); i++) begin
                    bm[a+i] = wd[8*i +: 8];
                    kn[a+i] = 1'b1;
                end
                tg[w] = (k == 2'd3) ? wt : 1'b0;
            end else begin
                for (int i = 0; i < int'(n); i++) begin
                    er[8*i +: 8] = bm[a+i];
                    if (!kn[a+i]) ekn = 1'b0;
                end
                et = (k == 2'd3) ? tg[w] : 1'b0;
            end
        end
        req_valid = 1'b1; req_we = we; req_kind = k;
        req_addr = ADDR_W'(a); req_wdata = wd; req_wtag = wt;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, rq, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
        chk(rsp_err === ee, rq, "rsp_err", {63'd0, rsp_err}, {63'd0, ee});
        chk(rsp_tag === et, rq, "rsp_tag", {63'd0, rsp_tag}, {63'd0, et});
        if (ekn) chk(rsp_rdata === er, rq, "rsp_rdata", rsp_rdata, er);
    endtask

    task automatic idle(input string rq);
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b0, rq, "idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic sweep(input string rq);
        for (int w = 0; w < int'(DEPTH); w++) op(1'b0, 2'd3, w * 8, '0, 1'b0, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(NBYTES); i++) begin bm[i] = '0; kn[i] = 1'b0; end
        for (int i = 0; i < int'(DEPTH); i++) tg[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R2: not ready and no response in reset
        chk(req_ready === 1'b0, "R2", "ready in reset", {63'd0, req_ready}, 64'd0);
        chk(rsp_valid === 1'b0, "R1", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R2", "ready after reset", {63'd0, req_ready}, 64'd1);
        idle("R1");
        // R1: all tags zero after reset
        sweep("R1");
        // R6: fill with capability stores, mixed tags
        for (int w = 0; w < int'(DEPTH); w++)
            op(1'b1, 2'd3, w * 8, {32'hC0DE_0000 | w, 32'h1234_5678 ^ w}, (w % 3) != 0, "R6");
        idle("R2");
        sweep("R7");
        // R5, R4: data stores of each size into tagged words
        op(1'b1, 2'd0, 1*8 + 5, 64'hFFFF_FFFF_FFFF_00A5, 1'b1, "R5");
        op(1'b1, 2'd1, 2*8 + 6, 64'h0000_0000_0000_BEEF, 1'b1, "R5");
        op(1'b1, 2'd2, 4*8 + 4, 64'h0000_0000_CAFE_F00D, 1'b1, "R5");
        op(1'b0, 2'd3, 1*8, '0, 1'b0, "R4");
        op(1'b0, 2'd3, 2*8, '0, 1'b0, "R4");
        op(1'b0, 2'd3, 4*8, '0, 1'b0, "R5");
        // R3: data loads of each size; tag of word 5 stays set
        op(1'b0, 2'd0, 5*8 + 7, '0, 1'b0, "R3");
        op(1'b0, 2'd1, 5*8 + 2, '0, 1'b0, "R3");
        op(1'b0, 2'd2, 5*8 + 4, '0, 1'b0, "R3");
        op(1'b0, 2'd3, 5*8, '0, 1'b0, "R3");
        // R8: misaligned capability store and load, no state change
        op(1'b1, 2'd3, 7*8 + 4, 64'hDEAD_DEAD_DEAD_DEAD, 1'b0, "R8");
        op(1'b0, 2'd3, 8*8 + 1, '0, 1'b0, "R8");
        op(1'b0, 2'd3, 7*8, '0, 1'b0, "R8");
        op(1'b0, 2'd3, 8*8, '0, 1'b0, "R8");
        // R9: misaligned half and word stores, no state change
        op(1'b1, 2'd1, 10*8 + 3, 64'h0000_0000_0000_7777, 1'b0, "R9");
        op(1'b1, 2'd2, 11*8 + 2, 64'h0000_0000_9999_9999, 1'b0, "R9");
        op(1'b0, 2'd2, 11*8 + 6, '0, 1'b0, "R10");
        op(1'b0, 2'd3, 10*8, '0, 1'b0, "R9");
        op(1'b0, 2'd3, 11*8, '0, 1'b0, "R9");
        idle("R2");
        // R11: store acknowledgements, back-to-back with loads
        op(1'b1, 2'd3, 12*8, 64'h0123_4567_89AB_CDEF, 1'b1, "R11");
        op(1'b0, 2'd3, 12*8, '0, 1'b0, "R6");
        op(1'b1, 2'd3, 12*8, 64'h0123_4567_89AB_CDEF, 1'b0, "R6");
        op(1'b0, 2'd3, 12*8, '0, 1'b0, "R6");
        // R4: random mix of sizes, alignments and directions
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] k;
            int unsigned a, n;
            k = 2'($urandom % 4);
            n = (k == 2'd0) ? 1 : (k == 2'd1) ? 2 : (k == 2'd2) ? 4 : 8;
            a = $urandom % NBYTES;
            if (($urandom % 4) != 0) a = a - (a % n);
            if (($urandom % 8) == 0) idle("R2");
            else op(1'($urandom % 2), k, a, {$urandom, $urandom}, 1'($urandom % 2), "R4");
        end
        sweep("R5");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule